// File: doc/BRIEF.md
# Processor Status Word Flag Unit

This block holds the eight condition and mode flags of a small 8-bit microcontroller core in one status byte. Each cycle it takes the ALU result and its side indications (carry-out, carry out of bit 3, signed overflow) and updates only the flags whose update strobes are raised. The instruction decoder drives one-cycle control pulses for flag set and clear instructions, for the bit-test instruction, for interrupt acknowledge and for a software break. A whole-byte load restores the register on a pop or a return from interrupt.

The direct-page flag moves the direct-addressing window. The block combines that flag with the 8-bit direct operand to form a 9-bit address. The ALU, the decoder and the interrupt controller are outside this block.

Top module: `psw_flag_unit`

## Requirements
- R1: After reset the status byte is 00h. Its bit layout from bit 7 down to bit 0 is N, V, G, B, H, I, Z, C, and each single-flag output equals its bit of the byte.
- R2: When `ld_en` is high, the next status byte equals `ld_val`, whatever other strobes or pulses are active in that cycle.
- R3: When `upd_z` is high, Z becomes 1 if `alu_res` is zero and 0 otherwise.
- R4: When `upd_n` is high, N takes bit 7 of `alu_res`. When `bt_en` is high, N instead takes `bt_hi[1]` (operand bit 7). The bit test wins over `upd_n`.
- R5: When `upd_v` is high, V takes `alu_ovf`. When `bt_en` is high, V takes `bt_hi[0]` (operand bit 6), and this wins over `upd_v`. When `clr_vh` is high, both V and H become 0, and this wins over the bit test and over every ALU update.
- R6: When `upd_h` is high and `clr_vh` is low, H takes `alu_hc`, the ALU's carry out of bit 3 (or no-borrow from bit 4).
- R7: When `upd_c` is high, C takes `alu_co`.
- R8: `set_g` sets G and `clr_g` clears it. If both are high, clear wins. `dp_addr` is combinationally {G, `dp_off`}: the range 000h–0FFh when G is 0 and 100h–1FFh when G is 1.
- R9: `set_i` sets I. `clr_i` and `irq_ack` each clear it, and a clear wins over `set_i`.
- R10: `brk` sets B. After that, B changes only through a byte load or reset.
- R11: A flag whose strobes and pulses are all low holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_res | input | 8 | ALU result byte |
| alu_co | input | 1 | ALU carry-out |
| alu_hc | input | 1 | ALU carry out of bit 3 / no-borrow from bit 4 |
| alu_ovf | input | 1 | ALU signed overflow |
| upd_n | input | 1 | Update N from the result |
| upd_v | input | 1 | Update V from the overflow |
| upd_h | input | 1 | Update H from the half carry |
| upd_z | input | 1 | Update Z from the result |
| upd_c | input | 1 | Update C from the carry-out |
| bt_en | input | 1 | Bit-test instruction pulse |
| bt_hi | input | 2 | Memory operand bits 7 and 6 |
| clr_vh | input | 1 | Clear-overflow instruction (clears V and H) |
| set_g | input | 1 | Set direct-page flag |
| clr_g | input | 1 | Clear direct-page flag |
| set_i | input | 1 | Interrupt enable instruction |
| clr_i | input | 1 | Interrupt disable instruction |
| irq_ack | input | 1 | Interrupt served pulse |
| brk | input | 1 | Software break pulse |
| ld_en | input | 1 | Whole-byte load (pop / return) |
| ld_val | input | 8 | Byte to load |
| dp_off | input | 8 | Direct-addressing operand |
| psw | output | 8 | Status byte |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_g | output | 1 | Direct-page flag |
| flag_b | output | 1 | Break flag |
| flag_h | output | 1 | Half-carry flag |
| flag_i | output | 1 | Interrupt enable flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| dp_addr | output | 9 | Direct-page address |

## Verification
A long run of random stimulus is compared on every clock against a behavioural model. In that run the strobes are sparse, so that held flags (R11) and single updates can be seen apart from overlapping ones. Directed cycles raise the conflicting pulses together: the bit test with the ALU strobes, clear-overflow with the bit test, a clear with a set on G and I, and a byte load with everything else. These cycles tell each priority order apart. Zero and non-zero result bytes tell Z apart, and both values of G are each combined with several operands to show that `dp_addr` moves between the two pages.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W = 8;

  typedef struct packed {
    logic n;
    logic v;
    logic g;
    logic b;
    logic h;
    logic i;
    logic z;
    logic c;
  } psw_t;
endpackage

// File: rtl/psw_alu_flags.sv
module psw_alu_flags #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] res,
  input  logic              co,
  input  logic              hc,
  input  logic              ovf,
  input  logic              up_n,
  input  logic              up_v,
  input  logic              up_h,
  input  logic              up_z,
  input  logic              up_c,
  input  logic              tst,
  input  logic [1:0]        tst_bits,
  input  logic              clr_ovh,
  input  logic              cur_n,
  input  logic              cur_v,
  input  logic              cur_h,
  input  logic              cur_z,
  input  logic              cur_c,
  output logic              n_nx,
  output logic              v_nx,
  output logic              h_nx,
  output logic              z_nx,
  output logic              c_nx
);
  localparam int SIGN_B = DATA_W - 1;

  always_comb begin
    n_nx = cur_n;
    if (tst)       n_nx = tst_bits[1];
    else if (up_n) n_nx = res[SIGN_B];

    v_nx = cur_v;
    if (clr_ovh)   v_nx = 1'b0;
    else if (tst)  v_nx = tst_bits[0];
    else if (up_v) v_nx = ovf;

    h_nx = cur_h;
    if (clr_ovh)   h_nx = 1'b0;
    else if (up_h) h_nx = hc;

    z_nx = cur_z;
    if (up_z)      z_nx = (res == '0);

    c_nx = cur_c;
    if (up_c)      c_nx = co;
  end
endmodule

// File: rtl/psw_ctrl_flags.sv
module psw_ctrl_flags (
  input  logic cur_g,
  input  logic cur_i,
  input  logic cur_b,
  input  logic g_set,
  input  logic g_clr,
  input  logic i_set,
  input  logic i_clr,
  input  logic ack,
  input  logic brk_p,
  output logic g_nx,
  output logic i_nx,
  output logic b_nx
);
  always_comb begin
    g_nx = cur_g;
    if (g_clr)        g_nx = 1'b0;
    else if (g_set)   g_nx = 1'b1;

    i_nx = cur_i;
    if (i_clr || ack) i_nx = 1'b0;
    else if (i_set)   i_nx = 1'b1;

    b_nx = cur_b;
    if (brk_p)        b_nx = 1'b1;
  end
endmodule

// File: rtl/psw_dpage.sv
module psw_dpage #(
  parameter int OFF_W = 8
) (
  input  logic             page_sel,
  input  logic [OFF_W-1:0] off,
  output logic [OFF_W:0]   addr
);
  always_comb begin
    addr = {page_sel, off};
  end
endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
  import psw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSW_W-1:0] alu_res,
  input  logic             alu_co,
  input  logic             alu_hc,
  input  logic             alu_ovf,
  input  logic             upd_n,
  input  logic             upd_v,
  input  logic             upd_h,
  input  logic             upd_z,
  input  logic             upd_c,
  input  logic             bt_en,
  input  logic [1:0]       bt_hi,
  input  logic             clr_vh,
  input  logic             set_g,
  input  logic             clr_g,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic             irq_ack,
  input  logic             brk,
  input  logic             ld_en,
  input  logic [PSW_W-1:0] ld_val,
  input  logic [PSW_W-1:0] dp_off,
  output logic [PSW_W-1:0] psw,
  output logic             flag_n,
  output logic             flag_v,
  output logic             flag_g,
  output logic             flag_b,
  output logic             flag_h,
  output logic             flag_i,
  output logic             flag_z,
  output logic             flag_c,
  output logic [PSW_W:0]   dp_addr
);
  psw_t cur_q;
  psw_t upd_d;
  psw_t nxt_d;
  logic any_evt;

  psw_alu_flags #(.DATA_W(PSW_W)) u_alu (
    .res(alu_res), .co(alu_co), .hc(alu_hc), .ovf(alu_ovf),
    .up_n(upd_n), .up_v(upd_v), .up_h(upd_h), .up_z(upd_z), .up_c(upd_c),
    .tst(bt_en), .tst_bits(bt_hi), .clr_ovh(clr_vh),
    .cur_n(cur_q.n), .cur_v(cur_q.v), .cur_h(cur_q.h),
    .cur_z(cur_q.z), .cur_c(cur_q.c),
    .n_nx(upd_d.n), .v_nx(upd_d.v), .h_nx(upd_d.h),
    .z_nx(upd_d.z), .c_nx(upd_d.c)
  );

  psw_ctrl_flags u_ctrl (
    .cur_g(cur_q.g), .cur_i(cur_q.i), .cur_b(cur_q.b),
    .g_set(set_g), .g_clr(clr_g), .i_set(set_i), .i_clr(clr_i),
    .ack(irq_ack), .brk_p(brk),
    .g_nx(upd_d.g), .i_nx(upd_d.i), .b_nx(upd_d.b)
  );

  psw_dpage #(.OFF_W(PSW_W)) u_dp (
    .page_sel(cur_q.g), .off(dp_off), .addr(dp_addr)
  );

  // Next-state: a whole-byte load overrides every individual update.
  always_comb begin
    nxt_d = upd_d;
    if (ld_en) nxt_d = psw_t'(ld_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt_d;
  end

  assign psw    = cur_q;
  assign flag_n = cur_q.n;
  assign flag_v = cur_q.v;
  assign flag_g = cur_q.g;
  assign flag_b = cur_q.b;
  assign flag_h = cur_q.h;
  assign flag_i = cur_q.i;
  assign flag_z = cur_q.z;
  assign flag_c = cur_q.c;

  assign any_evt = upd_n | upd_v | upd_h | upd_z | upd_c | bt_en | clr_vh |
                   set_g | clr_g | set_i | clr_i | irq_ack | brk | ld_en;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> psw == $past(ld_val)); // R2
  AST_CLRVH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vh && !ld_en) |=> (!flag_v && !flag_h)); // R5
  AST_ACK_CLEARS_I: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !ld_en) |=> !flag_i); // R9
  AST_BRK_SETS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && !ld_en) |=> flag_b); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !any_evt |=> $stable(psw)); // R11
  AST_BT_TAKES_N: assert property (@(posedge clk) disable iff (!rst_n)
    (bt_en && !ld_en) |=> flag_n == $past(bt_hi[1])); // R4
endmodule

// File: tb/psw_flag_unit_tb_top.sv
`timescale 1ns/1ps
module psw_flag_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] alu_res = '0, ld_val = '0, dp_off = '0;
  logic alu_co = 0, alu_hc = 0, alu_ovf = 0;
  logic upd_n = 0, upd_v = 0, upd_h = 0, upd_z = 0, upd_c = 0;
  logic bt_en = 0, clr_vh = 0, set_g = 0, clr_g = 0, set_i = 0, clr_i = 0;
  logic irq_ack = 0, brk = 0, ld_en = 0;
  logic [1:0] bt_hi = '0;
  logic [7:0] psw;
  logic flag_n, flag_v, flag_g, flag_b, flag_h, flag_i, flag_z, flag_c;
  logic [8:0] dp_addr;

  int n_chk = 0, n_fail = 0;
  int unsigned mdl = 0; // model byte, bit 7..0 = N V G B H I Z C

  always #4 clk = ~clk;

  psw_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .alu_res(alu_res), .alu_co(alu_co), .alu_hc(alu_hc),
    .alu_ovf(alu_ovf), .upd_n(upd_n), .upd_v(upd_v), .upd_h(upd_h), .upd_z(upd_z),
    .upd_c(upd_c), .bt_en(bt_en), .bt_hi(bt_hi), .clr_vh(clr_vh), .set_g(set_g),
    .clr_g(clr_g), .set_i(set_i), .clr_i(clr_i), .irq_ack(irq_ack), .brk(brk),
    .ld_en(ld_en), .ld_val(ld_val), .dp_off(dp_off), .psw(psw), .flag_n(flag_n),
    .flag_v(flag_v), .flag_g(flag_g), .flag_b(flag_b), .flag_h(flag_h),
    .flag_i(flag_i), .flag_z(flag_z), .flag_c(flag_c), .dp_addr(dp_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int unsigned setb(int unsigned v, int pos, bit val);
    if (val) return v | (32'd1 << pos);
    return v & ~(32'd1 << pos);
  endfunction

  // Behavioural reference of one clock edge.
  task automatic model_step();
    int unsigned m = mdl;
    if (ld_en) begin
      mdl = ld_val;
      return;
    end
    if (upd_z) m = setb(m, 1, alu_res == 8'd0);
    if (upd_c) m = setb(m, 0, alu_co);
    if (bt_en) m = setb(m, 7, bt_hi[1]); else if (upd_n) m = setb(m, 7, alu_res[7]);
    if (upd_v) m = setb(m, 6, alu_ovf);
    if (bt_en) m = setb(m, 6, bt_hi[0]);
    if (upd_h) m = setb(m, 3, alu_hc);
    if (clr_vh) begin m = setb(m, 6, 0); m = setb(m, 3, 0); end
    if (set_g) m = setb(m, 5, 1);
    if (clr_g) m = setb(m, 5, 0);
    if (set_i) m = setb(m, 2, 1);
    if (clr_i || irq_ack) m = setb(m, 2, 0);
    if (brk) m = setb(m, 4, 1);
    mdl = m;
  endtask

  task automatic compare_all();
    chk("R4 N", int'(flag_n), int'(mdl[7]));
    chk("R5 V", int'(flag_v), int'(mdl[6]));
    chk("R8 G", int'(flag_g), int'(mdl[5]));
    chk("R10 B", int'(flag_b), int'(mdl[4]));
    chk("R6 H", int'(flag_h), int'(mdl[3]));
    chk("R9 I", int'(flag_i), int'(mdl[2]));
    chk("R3 Z", int'(flag_z), int'(mdl[1]));
    chk("R7 C", int'(flag_c), int'(mdl[0]));
    chk("R1 byte", int'(psw), int'(mdl[7:0]));
    chk("R8 dp_addr", int'(dp_addr), int'({mdl[5], dp_off}));
  endtask

  task automatic idle();
    {upd_n, upd_v, upd_h, upd_z, upd_c, bt_en, clr_vh, set_g, clr_g} = '0;
    {set_i, clr_i, irq_ack, brk, ld_en} = '0;
  endtask

  // Inputs are set before the call (after a negedge); step through one edge.
  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(8 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", int'(psw), 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R2: load with every other pulse raised
    {upd_n, upd_v, upd_h, upd_z, upd_c, bt_en, clr_vh, set_g, clr_g} = '1;
    {set_i, clr_i, irq_ack, brk} = '1;
    ld_en = 1; ld_val = 8'hA5; step();
    chk("R2 load", int'(psw), 8'hA5);
    idle();
    // R11: idle cycles hold
    step(); step();
    chk("R11 hold", int'(psw), 8'hA5);
    // R5: clear-overflow beats bit test and ALU updates
    ld_en = 1; ld_val = 8'hFF; step(); idle();
    clr_vh = 1; bt_en = 1; bt_hi = 2'b11; upd_v = 1; alu_ovf = 1; upd_h = 1; alu_hc = 1;
    step(); idle();
    chk("R5 clr_vh", int'(psw), 8'hB7);
    // R4: bit test beats upd_n
    bt_en = 1; bt_hi = 2'b01; upd_n = 1; alu_res = 8'h80; step(); idle();
    chk("R4 bt N", int'(flag_n), 0);
    chk("R5 bt V", int'(flag_v), 1);
    // R3: zero / non-zero result
    upd_z = 1; alu_res = 8'h00; step();
    chk("R3 zero", int'(flag_z), 1);
    alu_res = 8'h01; step(); idle();
    chk("R3 nonzero", int'(flag_z), 0);
    // R8 / R9: clear wins over set
    set_g = 1; clr_g = 1; set_i = 1; irq_ack = 1; step(); idle();
    chk("R8 clr wins", int'(flag_g), 0);
    chk("R9 ack wins", int'(flag_i), 0);
    set_g = 1; dp_off = 8'h3C; step(); idle();
    chk("R8 page1", int'(dp_addr), 9'h13C);

    // Random run with sparse strobes
    for (int k = 0; k < 3000; k++) begin
      alu_res = 8'($urandom); alu_co = 1'($urandom); alu_hc = 1'($urandom);
      alu_ovf = 1'($urandom); bt_hi = 2'($urandom); dp_off = 8'($urandom);
      ld_val = 8'($urandom);
      upd_n = ($urandom % 4) == 0; upd_v = ($urandom % 4) == 0;
      upd_h = ($urandom % 4) == 0; upd_z = ($urandom % 4) == 0;
      upd_c = ($urandom % 4) == 0; bt_en = ($urandom % 8) == 0;
      clr_vh = ($urandom % 10) == 0; set_g = ($urandom % 8) == 0;
      clr_g = ($urandom % 8) == 0; set_i = ($urandom % 6) == 0;
      clr_i = ($urandom % 10) == 0; irq_ack = ($urandom % 10) == 0;
      brk = ($urandom % 20) == 0; ld_en = ($urandom % 25) == 0;
      step();
    end
    idle();
    step();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule